// File: doc/BRIEF.md
# Walk Request Sequencer

This block sits between a page-table walker and a memory port that can turn requests away. The walker hands it at most one pending entry read at a time, along with write-backs that set the accessed flag on table entries. The sequencer presents these to memory one per cycle, and a pending read always goes ahead of write-backs. The write-backs wait on a small stack and leave it newest first.

When the port refuses a request, the sequencer keeps that request and stops presenting anything until the port sends a retry pulse. A response marked as not acknowledged puts its request back in the pending set, so it is sent again at the next chance. The block keeps count of accepted requests that still await a good response. A walk ends only after the walker has marked its last step, every accepted request has been answered, no read is waiting and the write-back stack is empty. At that point the block emits a one-cycle completion pulse together with the fault flag the walker gave at its last step.

The block also puts walks in order. Walk requests go into a first-in first-out queue, and the oldest one is launched whenever no walk is active. A walk that arrives while another runs waits and starts only after the running walk has completed.

Top module: `wsq_sequencer`

## Requirements
- R1: When a read is pending, the presented request is that read (`mem_we_o` = 0, `mem_wdata_o` = 0), even when write-backs are waiting.
- R2: With no read pending, write-backs are presented newest first (`mem_we_o` = 1); the stack top is the entry pushed last.
- R3: At most one request is presented per cycle. It is taken in a cycle where `mem_accept_i` is 1, and it stays outstanding until a response for it arrives with `mem_resp_nack_i` = 0.
- R4: A refused request (`mem_req_o` = 1, `mem_accept_i` = 0) parks the block. `mem_req_o` stays 0 from the next cycle until a cycle with `mem_retry_i` = 1, and the refused request is kept unchanged. A retry pulse while not parked has no effect.
- R5: A nacked read response makes its address the pending read again. A nacked write response pushes its address and data back on top of the write-back stack. In both cases the request is presented again at the next issue opportunity.
- R6: `done_o` is 1 for exactly one cycle once all of these hold: end of walk has been marked through `end_i`, nothing is outstanding, no read is pending and the stack is empty. `done_fault_o` then shows the `end_fault_i` value captured with `end_i`.
- R7: `wb_full_o` is 1 when stacked write-backs plus outstanding writes equal `WB_DEPTH`. A `wb_load_i` while `wb_full_o` is 1 is ignored.
- R8: Walk requests are queued in arrival order. `launch_o` is a one-cycle pulse with the oldest queued id in `launch_id_o`, given only while no walk is active. The next launch comes no earlier than the cycle after `done_o`.
- R9: After reset: `mem_req_o`, `launch_o`, `done_o` and `wb_full_o` are 0 and `start_ready_o` is 1.
- R10: `start_ready_o` is 0 when the walk queue holds `WALK_DEPTH` ids. A `start_req_i` in such a cycle is dropped.
- R11: Within one cycle the stack is updated in this order: a pop for an accepted write-back, then a push of a nacked write, then a push from `wb_load_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_req_i | input | 1 | New walk request |
| start_id_i | input | ID_W | Id of the new walk |
| start_ready_o | output | 1 | Walk queue has room |
| launch_o | output | 1 | Start the walk shown on launch_id_o |
| launch_id_o | output | ID_W | Id of the walk being launched |
| rd_load_i | input | 1 | Walker supplies the next entry read |
| rd_addr_i | input | ADDR_W | Address of that read |
| wb_load_i | input | 1 | Walker supplies an accessed-flag write-back |
| wb_addr_i | input | ADDR_W | Write-back address |
| wb_data_i | input | DATA_W | Write-back data |
| wb_full_o | output | 1 | Write-back capacity used up |
| end_i | input | 1 | Walker has taken its final step |
| end_fault_i | input | 1 | Final step raised a fault |
| done_o | output | 1 | Walk fully complete |
| done_fault_o | output | 1 | Fault result of the completed walk |
| mem_req_o | output | 1 | Request presented to memory |
| mem_we_o | output | 1 | Request is a write-back |
| mem_addr_o | output | ADDR_W | Request address |
| mem_wdata_o | output | DATA_W | Write-back data |
| mem_accept_i | input | 1 | Port takes the presented request this cycle |
| mem_retry_i | input | 1 | Port can take requests again |
| mem_resp_i | input | 1 | Response arrives |
| mem_resp_nack_i | input | 1 | Response is a negative acknowledgement |
| mem_resp_we_i | input | 1 | Response belongs to a write-back |
| mem_resp_addr_i | input | ADDR_W | Address of the answered request |
| mem_resp_data_i | input | DATA_W | Write data of the answered request |

## Verification
Two kinds of event can land in the same cycle. A nacked write-back can return while the stack is popping for an accepted write-back and the walker is also pushing a new one. A refusal can likewise fall in the same cycle as a retry pulse, or next to one. The bench drives accept, retry, responses (about one in five nacked) and walker pushes independently at random, so these coincidences occur many times. It judges each cycle by comparing the presented address, data and type against a queue-based model that applies the pop-then-nack-then-load order.

// File: rtl/wsq_pkg.sv
package wsq_pkg;

   // source of the request presented to memory in a cycle
   typedef enum logic [1:0] {
      SRC_IDLE  = 2'd0,
      SRC_READ  = 2'd1,
      SRC_WBACK = 2'd2
   } src_e;

   // bits needed to hold the values 0 .. n-1
   function automatic int cnt_bits(input int n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/wsq_lifo.sv
module wsq_lifo #(
   parameter int WIDTH = 32,
   parameter int DEPTH = 4,
   parameter int CW    = wsq_pkg::cnt_bits(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pop_i,
   input  logic             push_a_i,
   input  logic [WIDTH-1:0] data_a_i,
   input  logic             push_b_i,
   input  logic [WIDTH-1:0] data_b_i,
   output logic [WIDTH-1:0] top_o,
   output logic [CW-1:0]    count_o
);

   logic [WIDTH-1:0] slot_q [DEPTH];
   logic [CW-1:0]    cnt_q;
   logic [CW-1:0]    base;
   logic [CW-1:0]    slot_b;

   // pop first, then push a, then push b
   assign base   = cnt_q - CW'(pop_i);
   assign slot_b = base + CW'(push_a_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= slot_b + CW'(push_b_i);
   end

   always_ff @(posedge clk) begin
      for (int i = 0; i < DEPTH; i++) begin
         if (push_a_i && base == CW'(i))
            slot_q[i] <= data_a_i;
         else if (push_b_i && slot_b == CW'(i))
            slot_q[i] <= data_b_i;
      end
   end

   always_comb begin
      top_o = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (cnt_q == CW'(i + 1)) top_o = slot_q[i];
      end
   end

   assign count_o = cnt_q;

endmodule

// File: rtl/wsq_outstanding.sv
module wsq_outstanding #(
   parameter int WB_DEPTH = 4,
   parameter int TW       = wsq_pkg::cnt_bits(WB_DEPTH + 2),
   parameter int WW       = wsq_pkg::cnt_bits(WB_DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          send_i,
   input  logic          send_wr_i,
   input  logic          resp_i,
   input  logic          resp_wr_i,
   output logic [TW-1:0] total_o,
   output logic [WW-1:0] writes_o
);

   logic [TW-1:0] total_q;
   logic [WW-1:0] writes_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         total_q  <= '0;
         writes_q <= '0;
      end else begin
         total_q  <= total_q + TW'(send_i) - TW'(resp_i);
         writes_q <= writes_q + WW'(send_wr_i) - WW'(resp_wr_i);
      end
   end

   assign total_o  = total_q;
   assign writes_o = writes_q;

endmodule

// File: rtl/wsq_walk_fifo.sv
module wsq_walk_fifo #(
   parameter int IDW   = 4,
   parameter int DEPTH = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           push_i,
   input  logic [IDW-1:0] id_i,
   input  logic           pop_i,
   output logic [IDW-1:0] head_o,
   output logic           empty_o,
   output logic           full_o
);

   if (DEPTH == 1) begin : g_single
      logic           vld_q;
      logic [IDW-1:0] id_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld_q <= 1'b0;
            id_q  <= '0;
         end else if (push_i) begin
            vld_q <= 1'b1;
            id_q  <= id_i;
         end else if (pop_i) begin
            vld_q <= 1'b0;
         end
      end

      assign head_o  = id_q;
      assign empty_o = !vld_q;
      assign full_o  = vld_q;
   end else begin : g_ring
      localparam int PW = $clog2(DEPTH);
      localparam int CW = $clog2(DEPTH + 1);

      logic [IDW-1:0] ring_q [DEPTH];
      logic [PW-1:0]  rd_q, wr_q;
      logic [CW-1:0]  cnt_q;

      function automatic logic [PW-1:0] adv(input logic [PW-1:0] p);
         return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
      endfunction

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
         end else begin
            if (push_i) wr_q <= adv(wr_q);
            if (pop_i)  rd_q <= adv(rd_q);
            cnt_q <= cnt_q + CW'(push_i) - CW'(pop_i);
         end
      end

      always_ff @(posedge clk) begin
         if (push_i) ring_q[wr_q] <= id_i;
      end

      assign head_o  = ring_q[rd_q];
      assign empty_o = (cnt_q == '0);
      assign full_o  = (cnt_q == CW'(DEPTH));
   end

endmodule

// File: rtl/wsq_sequencer.sv
module wsq_sequencer
   import wsq_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 64,
   parameter int ID_W       = 4,
   parameter int WB_DEPTH   = 4,
   parameter int WALK_DEPTH = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_req_i,
   input  logic [ID_W-1:0]   start_id_i,
   output logic              start_ready_o,
   output logic              launch_o,
   output logic [ID_W-1:0]   launch_id_o,
   input  logic              rd_load_i,
   input  logic [ADDR_W-1:0] rd_addr_i,
   input  logic              wb_load_i,
   input  logic [ADDR_W-1:0] wb_addr_i,
   input  logic [DATA_W-1:0] wb_data_i,
   output logic              wb_full_o,
   input  logic              end_i,
   input  logic              end_fault_i,
   output logic              done_o,
   output logic              done_fault_o,
   output logic              mem_req_o,
   output logic              mem_we_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic [DATA_W-1:0] mem_wdata_o,
   input  logic              mem_accept_i,
   input  logic              mem_retry_i,
   input  logic              mem_resp_i,
   input  logic              mem_resp_nack_i,
   input  logic              mem_resp_we_i,
   input  logic [ADDR_W-1:0] mem_resp_addr_i,
   input  logic [DATA_W-1:0] mem_resp_data_i
);

   localparam int ENT_W = ADDR_W + DATA_W;
   localparam int WBCW  = cnt_bits(WB_DEPTH + 1);
   localparam int IFW   = cnt_bits(WB_DEPTH + 2);

   if (WB_DEPTH < 1 || WALK_DEPTH < 1 || ADDR_W < 1 || DATA_W < 1 || ID_W < 1) begin : g_bad_cfg
      $error("wsq_sequencer: widths and depths must be at least 1");
   end

   logic              park_q;
   logic              rd_vld_q;
   logic [ADDR_W-1:0] rd_addr_q;
   logic              active_q;
   logic              end_q;
   logic              fault_q;

   logic [ENT_W-1:0]  wb_top;
   logic [WBCW-1:0]   wb_cnt;
   logic [WBCW-1:0]   wr_out;
   logic [IFW-1:0]    inflight;
   src_e              src;
   logic              sent, refused, pop_wb;
   logic              nack_rd, nack_wr, wb_take;
   logic              q_empty, q_full;

   // issue selection: parked -> nothing, read ahead of write-backs
   always_comb begin
      if (park_q)               src = SRC_IDLE;
      else if (rd_vld_q)        src = SRC_READ;
      else if (wb_cnt != '0)    src = SRC_WBACK;
      else                      src = SRC_IDLE;
   end

   assign mem_req_o   = (src != SRC_IDLE);
   assign mem_we_o    = (src == SRC_WBACK);
   assign mem_addr_o  = (src == SRC_WBACK) ? wb_top[ENT_W-1:DATA_W] : rd_addr_q;
   assign mem_wdata_o = (src == SRC_WBACK) ? wb_top[DATA_W-1:0] : '0;

   assign sent    = mem_req_o && mem_accept_i;
   assign refused = mem_req_o && !mem_accept_i;
   assign pop_wb  = sent && (src == SRC_WBACK);
   assign nack_rd = mem_resp_i && mem_resp_nack_i && !mem_resp_we_i;
   assign nack_wr = mem_resp_i && mem_resp_nack_i && mem_resp_we_i;

   assign wb_full_o = ({1'b0, wb_cnt} + {1'b0, wr_out}) >= (WBCW + 1)'(WB_DEPTH);
   assign wb_take   = wb_load_i && !wb_full_o;

   wsq_lifo #(.WIDTH(ENT_W), .DEPTH(WB_DEPTH), .CW(WBCW)) u_stack (
      .clk      (clk),
      .rst_n    (rst_n),
      .pop_i    (pop_wb),
      .push_a_i (nack_wr),
      .data_a_i ({mem_resp_addr_i, mem_resp_data_i}),
      .push_b_i (wb_take),
      .data_b_i ({wb_addr_i, wb_data_i}),
      .top_o    (wb_top),
      .count_o  (wb_cnt)
   );

   wsq_outstanding #(.WB_DEPTH(WB_DEPTH), .TW(IFW), .WW(WBCW)) u_track (
      .clk       (clk),
      .rst_n     (rst_n),
      .send_i    (sent),
      .send_wr_i (pop_wb),
      .resp_i    (mem_resp_i),
      .resp_wr_i (mem_resp_i && mem_resp_we_i),
      .total_o   (inflight),
      .writes_o  (wr_out)
   );

   wsq_walk_fifo #(.IDW(ID_W), .DEPTH(WALK_DEPTH)) u_walks (
      .clk     (clk),
      .rst_n   (rst_n),
      .push_i  (start_req_i && !q_full),
      .id_i    (start_id_i),
      .pop_i   (launch_o),
      .head_o  (launch_id_o),
      .empty_o (q_empty),
      .full_o  (q_full)
   );

   assign start_ready_o = !q_full;
   assign launch_o      = !active_q && !q_empty;
   assign done_o        = active_q && end_q && (inflight == '0) && !rd_vld_q && (wb_cnt == '0);
   assign done_fault_o  = fault_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         park_q    <= 1'b0;
         rd_vld_q  <= 1'b0;
         rd_addr_q <= '0;
         active_q  <= 1'b0;
         end_q     <= 1'b0;
         fault_q   <= 1'b0;
      end else begin
         if (refused)          park_q <= 1'b1;
         else if (mem_retry_i) park_q <= 1'b0;

         if (sent && src == SRC_READ) rd_vld_q <= 1'b0;
         if (nack_rd) begin
            rd_vld_q  <= 1'b1;
            rd_addr_q <= mem_resp_addr_i;
         end
         if (rd_load_i) begin
            rd_vld_q  <= 1'b1;
            rd_addr_q <= rd_addr_i;
         end

         if (end_i) begin
            end_q   <= 1'b1;
            fault_q <= end_fault_i;
         end else if (done_o) begin
            end_q   <= 1'b0;
         end

         if (launch_o)    active_q <= 1'b1;
         else if (done_o) active_q <= 1'b0;
      end
   end

endmodule

// File: rtl/wsq_checker.sv
module wsq_checker #(
   parameter int WB_DEPTH = 4,
   parameter int IFW      = 3,
   parameter int WBCW     = 3
) (
   input logic            clk,
   input logic            rst_n,
   input logic            mem_req_o,
   input logic            mem_accept_i,
   input logic            done_o,
   input logic            launch_o,
   input logic            active_q,
   input logic [IFW-1:0]  inflight,
   input logic [WBCW-1:0] wb_cnt,
   input logic [WBCW-1:0] wr_out
);

   // R4: refusal parks the issue side for at least the next cycle
   p_park_after_refusal_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && !mem_accept_i) |=> !mem_req_o);

   // R6: completion only with nothing outstanding and nothing presented
   p_done_clean_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (inflight == '0) && !mem_req_o);

   // R6: completion is a single-cycle pulse
   p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R7: write-back capacity is never exceeded
   p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ({1'b0, wb_cnt} + {1'b0, wr_out}) <= (WBCW + 1)'(WB_DEPTH));

   // R3: outstanding count bounded by one read plus the write-back capacity
   p_inflight_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      {1'b0, inflight} <= (IFW + 1)'(WB_DEPTH + 1));

   // R8: launch is a single-cycle pulse and requests only occur inside a walk
   p_launch_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      launch_o |=> !launch_o);

   p_req_in_walk_r8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_o |-> active_q);

endmodule

bind wsq_sequencer wsq_checker #(
   .WB_DEPTH (WB_DEPTH),
   .IFW      (IFW),
   .WBCW     (WBCW)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .mem_req_o    (mem_req_o),
   .mem_accept_i (mem_accept_i),
   .done_o       (done_o),
   .launch_o     (launch_o),
   .active_q     (active_q),
   .inflight     (inflight),
   .wb_cnt       (wb_cnt),
   .wr_out       (wr_out)
);

// File: tb/wsq_sequencer_bench.sv
module wsq_sequencer_bench;

   localparam int CLK_PERIOD = 10;
   localparam int AW   = 16;
   localparam int DW   = 16;
   localparam int IW   = 4;
   localparam int WB   = 4;
   localparam int WQ   = 4;
   localparam int NCYC = 4000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_PERIOD / 2) clk = ~clk;

   logic          start_req_i = 0, rd_load_i = 0, wb_load_i = 0, end_i = 0, end_fault_i = 0;
   logic [IW-1:0] start_id_i = '0;
   logic [AW-1:0] rd_addr_i = '0, wb_addr_i = '0, mem_resp_addr_i = '0;
   logic [DW-1:0] wb_data_i = '0, mem_resp_data_i = '0;
   logic          mem_accept_i = 0, mem_retry_i = 0, mem_resp_i = 0;
   logic          mem_resp_nack_i = 0, mem_resp_we_i = 0;
   logic          start_ready_o, launch_o, wb_full_o, done_o, done_fault_o;
   logic          mem_req_o, mem_we_o;
   logic [IW-1:0] launch_id_o;
   logic [AW-1:0] mem_addr_o;
   logic [DW-1:0] mem_wdata_o;

   wsq_sequencer #(.ADDR_W(AW), .DATA_W(DW), .ID_W(IW), .WB_DEPTH(WB), .WALK_DEPTH(WQ)) u_wsq_sequencer (
      .clk(clk), .rst_n(rst_n),
      .start_req_i(start_req_i), .start_id_i(start_id_i), .start_ready_o(start_ready_o),
      .launch_o(launch_o), .launch_id_o(launch_id_o),
      .rd_load_i(rd_load_i), .rd_addr_i(rd_addr_i),
      .wb_load_i(wb_load_i), .wb_addr_i(wb_addr_i), .wb_data_i(wb_data_i), .wb_full_o(wb_full_o),
      .end_i(end_i), .end_fault_i(end_fault_i), .done_o(done_o), .done_fault_o(done_fault_o),
      .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
      .mem_accept_i(mem_accept_i), .mem_retry_i(mem_retry_i),
      .mem_resp_i(mem_resp_i), .mem_resp_nack_i(mem_resp_nack_i), .mem_resp_we_i(mem_resp_we_i),
      .mem_resp_addr_i(mem_resp_addr_i), .mem_resp_data_i(mem_resp_data_i)
   );

   int checks = 0;
   int failures = 0;
   bit finished = 0;

   typedef struct {
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      bit            we;
      bit            nk;
   } item_t;

   // reference model state
   item_t         stk[$];
   item_t         outq[$];
   int            wq[$];
   bit            m_rdv, m_rdnk, m_park, m_active, m_end, m_fault;
   logic [AW-1:0] m_rda;
   int            m_infl, m_wrout;

   // walker emulation
   bit wk_on, pend_rd, pend_end;
   int wk_id, wk_steps, wk_target, next_id;

   // per-cycle scratch
   bit    e_req, e_we, e_full, e_done, e_launch, e_ready, resp_take, rnack;
   logic [AW-1:0] e_addr;
   logic [DW-1:0] e_wd;
   item_t ritem, it;
   string atag;

   task automatic chk(input string tag, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!finished) begin
         failures++;
         $display("FAIL watchdog expired actual=1 expected=0");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R9: outputs idle during reset
      chk("R9 mem_req reset", mem_req_o, 0);
      chk("R9 launch reset", launch_o, 0);
      chk("R9 done reset", done_o, 0);
      chk("R9 wb_full reset", wb_full_o, 0);
      chk("R9 start_ready reset", start_ready_o, 1);
      rst_n = 1'b1;

      for (int cyc = 0; cyc < NCYC; cyc++) begin
         // expected outputs from model state before the coming edge
         e_req    = !m_park && (m_rdv || stk.size() > 0);
         e_we     = !m_rdv;
         e_addr   = m_rdv ? m_rda : (stk.size() > 0 ? stk[$].a : '0);
         e_wd     = (!m_rdv && stk.size() > 0) ? stk[$].d : '0;
         e_full   = (stk.size() + m_wrout) >= WB;
         e_done   = m_active && m_end && m_infl == 0 && !m_rdv && stk.size() == 0;
         e_launch = !m_active && wq.size() > 0;
         e_ready  = wq.size() < WQ;

         // drive inputs for this cycle
         start_req_i  = ($urandom % 6 == 0);
         start_id_i   = next_id[IW-1:0];
         mem_accept_i = ($urandom % 4 != 0);
         mem_retry_i  = ($urandom % 3 == 0);
         resp_take = 0;
         rnack = 0;
         if (outq.size() > 0 && $urandom % 2 == 0) begin
            int k = $urandom % outq.size();
            ritem = outq[k];
            outq.delete(k);
            resp_take = 1;
            rnack = ($urandom % 5 == 0);
         end
         mem_resp_i      = resp_take;
         mem_resp_nack_i = resp_take && rnack;
         mem_resp_we_i   = resp_take && ritem.we;
         mem_resp_addr_i = resp_take ? ritem.a : '0;
         mem_resp_data_i = resp_take ? ritem.d : '0;
         rd_load_i   = pend_rd;
         rd_addr_i   = {wk_id[3:0], wk_steps[11:0]};
         end_i       = pend_end;
         end_fault_i = ($urandom % 2 == 0);
         wb_load_i   = wk_on && !pend_end && ($urandom % 3 == 0) && (!e_full || $urandom % 3 == 0);
         wb_addr_i   = AW'($urandom);
         wb_data_i   = DW'($urandom);

         #1;
         chk("R4 mem_req", mem_req_o, e_req);
         if (e_req) begin
            if (m_rdv) atag = m_rdnk ? "R5 reissued read addr" : "R1 read addr";
            else       atag = stk[$].nk ? "R5 reissued write addr" : "R2 R11 write-back addr";
            chk("R1 request type", mem_we_o, e_we);
            chk(atag, mem_addr_o, e_addr);
            chk("R1 R2 R11 write data", mem_wdata_o, e_wd);
         end
         chk("R7 wb_full", wb_full_o, e_full);
         chk("R3 R6 done", done_o, e_done);
         if (e_done) chk("R6 done fault", done_fault_o, m_fault);
         chk("R8 launch", launch_o, e_launch);
         if (e_launch) chk("R8 launch id", launch_id_o, wq[0] % (1 << IW));
         chk("R10 start_ready", start_ready_o, e_ready);

         // model update for the edge
         pend_rd = 0;
         pend_end = 0;
         if (end_i) wk_on = 0;

         if (e_req && mem_accept_i) begin
            if (m_rdv) begin
               it.a = m_rda; it.d = '0; it.we = 0;
               m_rdv = 0;
            end else begin
               it = stk.pop_back();
               it.we = 1;
               m_wrout++;
            end
            it.nk = 0;
            outq.push_back(it);
            m_infl++;
         end
         if (e_req && !mem_accept_i) m_park = 1;
         else if (mem_retry_i)       m_park = 0;

         if (resp_take) begin
            m_infl--;
            if (ritem.we) m_wrout--;
            if (rnack) begin
               if (ritem.we) begin
                  it = ritem; it.nk = 1;
                  stk.push_back(it);
               end else begin
                  m_rdv = 1; m_rda = ritem.a; m_rdnk = 1;
               end
            end else if (!ritem.we) begin
               wk_steps++;
               if (wk_steps >= wk_target) pend_end = 1;
               else                       pend_rd = 1;
            end
         end
         if (wb_load_i && !e_full) begin
            it.a = wb_addr_i; it.d = wb_data_i; it.we = 1; it.nk = 0;
            stk.push_back(it);
         end
         if (rd_load_i) begin
            m_rdv = 1; m_rda = rd_addr_i; m_rdnk = 0;
         end
         if (end_i) begin
            m_end = 1; m_fault = end_fault_i;
         end
         if (e_done) begin
            m_active = 0; m_end = 0;
         end
         if (e_launch) begin
            m_active = 1;
            wk_id = wq.pop_front();
            wk_on = 1; wk_steps = 0;
            wk_target = 1 + ($urandom % 4);
            pend_rd = 1;
         end
         if (start_req_i && e_ready) wq.push_back(next_id % (1 << IW));
         if (start_req_i) next_id++;

         @(negedge clk);
      end

      finished = 1;
      summary();
      $finish;
   end

endmodule